// File: doc/BRIEF.md
# Speed Error Lock Detector and Limiter

This block watches a stream of signed speed error samples, each qualified by a valid strobe, and compares every sample with a programmable window made of an upper and a lower bound. A small down-counter tracks how many in-window samples have arrived in a row. When the programmed number has been seen, the block raises a lock output. That output is meant to switch on the downstream digital filter without any software involvement.

The same pair of bounds also drives an optional clamp. When the clamp is on, every sample is held inside the window before it is handed to the filter. When it is off, samples pass through unchanged. The output is registered and appears one cycle after the input strobe.

Software sees three word addresses. The two bounds are write-only. A control/status byte holds the clamp enable, the lock-count enable, the count preset, a two-bit mode field, an out-of-window status bit and a sticky saturation flag. A low-power re-initialisation input puts everything back to its reset state.

Top module: `spd_lock_limiter`

## Requirements
- R1: After reset, the upper bound is 0x7FFF and the lower bound is 0x8000. The control byte reads 0x00 and lock_o is low.
- R2: A read at address 0 (upper bound), address 1 (lower bound) or address 3 (unused) returns 0x0000.
- R3: A bound write takes effect only when both byte enables are set (reg_be = 2'b11). A write with a partial enable leaves the bound unchanged.
- R4: A sample is in the window when lower <= sample <= upper. Both comparisons are two's-complement signed and both ends are inclusive.
- R5: With lock counting enabled (control bit 2 = 1) and preset P in bits 1:0, lock_o rises in the cycle after the (P+1)-th consecutive in-window sample. It then stays high while in-window samples continue.
- R6: An out-of-window sample reloads the counter from P and clears lock_o. It also sets status bit 3. An in-window sample clears bit 3.
- R7: A read of control bits 1:0 returns the live counter value, not the written preset. Each in-window sample before lock lowers that value by one.
- R8: With control bit 2 = 0, the counter stays at P and lock_o stays low, whatever samples arrive.
- R9: out_valid is asserted exactly one cycle after smp_valid. With control bit 4 = 1, a sample below the lower bound is output as the lower bound and a sample above the upper bound as the upper bound. With bit 4 = 0, out_data equals the sample.
- R10: Control bit 5 is set by any sample equal to 0x7FFF or 0x8000. Writing 0 to bit 5 clears it. Writing 1 to bit 5 leaves it unchanged.
- R11: Control bits 7:6 read back as written. Writes to bit 3 are ignored.
- R12: A control write (address 2, reg_be[0] set) loads the counter with the newly written preset and clears lock_o.
- R13: A one-cycle pulse on lp_init restores every register, the counter and lock_o to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lp_init | input | 1 | Low-power entry, restores reset values |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 upper, 1 lower, 2 control |
| reg_be | input | DATA_W/8 | Byte enables for the write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Signed speed error sample |
| out_valid | output | 1 | Output sample strobe, one cycle after smp_valid |
| out_data | output | DATA_W | Clamped or passed-through sample |
| lock_o | output | 1 | Lock detected; enables the downstream filter |

## Verification
The bench builds the block with its defaults, DATA_W = 16 and the clamp present. This makes the signed extremes 0x7FFF and 0x8000 directly drivable, so the reset bounds, the saturation flag and the comparisons that must not overflow can be tested at their real limits. Inclusive window edges, partial-width bound writes, every preset from 0 to 3 and a control write in the middle of a count are each driven directly. A randomised stretch is then compared against a reference model kept in the bench.

// File: rtl/spd_lock_pkg.sv
// Shared constants and types for the speed error lock detector.
// Assumes a word register interface with three decoded addresses.
package spd_lock_pkg;
    localparam int CNT_W = 2;

    localparam logic [1:0] ADDR_UPPER = 2'd0;
    localparam logic [1:0] ADDR_LOWER = 2'd1;
    localparam logic [1:0] ADDR_CTRL  = 2'd2;

    // Control byte bit positions
    localparam int CB_MODE_LO = 6;
    localparam int CB_OVF     = 5;
    localparam int CB_LIM     = 4;
    localparam int CB_RANGE   = 3;
    localparam int CB_LOCKEN  = 2;

    typedef struct packed {
        logic [1:0]       mode;
        logic             lim_en;
        logic             lock_en;
        logic [CNT_W-1:0] preset;
    } ctrl_t;
endpackage

// File: rtl/spd_lock_regs.sv
// Register file: the two write-only bounds, the control fields and the
// sticky saturation flag. It also forms the read data.
// Assumes DATA_W is a multiple of 8 and at least 8.
module spd_lock_regs
    import spd_lock_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lp_init,
    input  logic                  reg_wr,
    input  logic [1:0]            reg_addr,
    input  logic [DATA_W/8-1:0]   reg_be,
    input  logic [DATA_W-1:0]     reg_wdata,
    input  logic                  sat_hit,
    input  logic [CNT_W-1:0]      cnt_live,
    input  logic                  range_flag,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic [DATA_W-1:0]     upper,
    output logic [DATA_W-1:0]     lower,
    output ctrl_t                 ctrl,
    output logic                  ovf,
    output logic                  ctrl_wr
);
    localparam logic [DATA_W-1:0] S_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] S_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    logic full_word;
    logic up_wr;
    logic lo_wr;
    logic [7:0] ctrl_byte;

    assign full_word = &reg_be;
    assign up_wr     = reg_wr && (reg_addr == ADDR_UPPER) && full_word;
    assign lo_wr     = reg_wr && (reg_addr == ADDR_LOWER) && full_word;
    assign ctrl_wr   = reg_wr && (reg_addr == ADDR_CTRL) && reg_be[0];

    // Bound registers: word writes only, extremes on reset.
    always_ff @(posedge clk) begin
        if (!rst_n || lp_init) begin
            upper <= S_MAX;
            lower <= S_MIN;
        end else begin
            if (up_wr) upper <= reg_wdata;
            if (lo_wr) lower <= reg_wdata;
        end
    end

    // Control fields that software writes directly.
    always_ff @(posedge clk) begin
        if (!rst_n || lp_init) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl.mode    <= reg_wdata[CB_MODE_LO+1:CB_MODE_LO];
            ctrl.lim_en  <= reg_wdata[CB_LIM];
            ctrl.lock_en <= reg_wdata[CB_LOCKEN];
            ctrl.preset  <= reg_wdata[CNT_W-1:0];
        end
    end

    // Sticky saturation flag: set by hardware, cleared only by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n || lp_init) begin
            ovf <= 1'b0;
        end else if (sat_hit) begin
            ovf <= 1'b1;
        end else if (ctrl_wr && !reg_wdata[CB_OVF]) begin
            ovf <= 1'b0;
        end
    end

    assign ctrl_byte = {ctrl.mode, ovf, ctrl.lim_en, range_flag, ctrl.lock_en, cnt_live};

    // Read mux: bounds and unused addresses read as zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_CTRL) reg_rdata[7:0] = ctrl_byte;
    end
endmodule

// File: rtl/spd_lock_window.sv
// Window compare and clamp. It flags in-window and saturated samples
// combinationally and registers the output sample one cycle later.
// Assumes bounds are signed values of the sample width.
module spd_lock_window #(
    parameter int DATA_W    = 16,
    parameter bit HAS_LIMIT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [DATA_W-1:0] upper,
    input  logic [DATA_W-1:0] lower,
    input  logic              lim_en,
    output logic              in_range,
    output logic              sat_hit,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam logic [DATA_W-1:0] S_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] S_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    logic signed [DATA_W-1:0] s_val;
    logic signed [DATA_W-1:0] s_hi;
    logic signed [DATA_W-1:0] s_lo;
    logic below;
    logic above;
    logic [DATA_W-1:0] lim_val;

    assign s_val    = smp_data;
    assign s_hi     = upper;
    assign s_lo     = lower;
    assign below    = s_val < s_lo;
    assign above    = s_val > s_hi;
    assign in_range = !below && !above;
    assign sat_hit  = smp_valid && ((smp_data == S_MAX) || (smp_data == S_MIN));

    generate
        if (HAS_LIMIT) begin : g_lim
            // Clamp the sample into the window when the limiter is on.
            always_comb begin
                if (!lim_en)    lim_val = smp_data;
                else if (below) lim_val = lower;
                else if (above) lim_val = upper;
                else            lim_val = smp_data;
            end
        end else begin : g_pass
            logic unused_lim;
            assign unused_lim = lim_en;
            assign lim_val    = smp_data;
        end
    endgenerate

    // Output register: one cycle of latency from the input strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= smp_valid;
            if (smp_valid) out_data <= lim_val;
        end
    end
endmodule

// File: rtl/spd_lock_counter.sv
// Consecutive-hit down-counter, lock flag and out-of-window status.
// Assumes in_range is meaningful only while smp_valid is high.
module spd_lock_counter
    import spd_lock_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lp_init,
    input  logic             smp_valid,
    input  logic             in_range,
    input  logic             lock_en,
    input  logic             ctrl_wr,
    input  logic [CNT_W-1:0] preset,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt,
    output logic             lock_o,
    output logic             range_flag
);
    // Counter and lock: a control write outranks disable, disable outranks samples.
    always_ff @(posedge clk) begin
        if (!rst_n || lp_init) begin
            cnt    <= '0;
            lock_o <= 1'b0;
        end else if (ctrl_wr) begin
            cnt    <= ld_val;
            lock_o <= 1'b0;
        end else if (!lock_en) begin
            cnt    <= preset;
            lock_o <= 1'b0;
        end else if (smp_valid) begin
            if (in_range) begin
                if (cnt == '0) lock_o <= 1'b1;
                else           cnt    <= cnt - 1'b1;
            end else begin
                cnt    <= preset;
                lock_o <= 1'b0;
            end
        end
    end

    // Out-of-window status follows the most recent sample.
    always_ff @(posedge clk) begin
        if (!rst_n || lp_init) begin
            range_flag <= 1'b0;
        end else if (smp_valid) begin
            range_flag <= !in_range;
        end
    end
endmodule

// File: rtl/spd_lock_limiter.sv
// Top level: connects the register file, the window/clamp stage and the
// lock counter. lock_o is the filter-enable for the next stage.
// Assumes a single clock and a synchronous active-low reset.
module spd_lock_limiter
    import spd_lock_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter bit HAS_LIMIT = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lp_init,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [DATA_W/8-1:0] reg_be,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                smp_valid,
    input  logic [DATA_W-1:0]   smp_data,
    output logic                out_valid,
    output logic [DATA_W-1:0]   out_data,
    output logic                lock_o
);
    logic [DATA_W-1:0] upper;
    logic [DATA_W-1:0] lower;
    ctrl_t             ctrl;
    logic              ovf;
    logic              ctrl_wr;
    logic              in_range;
    logic              sat_hit;
    logic [CNT_W-1:0]  cnt;
    logic              range_flag;
    logic              lock_en_w;
    logic              lim_en_w;

    assign lock_en_w = ctrl.lock_en;
    assign lim_en_w  = ctrl.lim_en;

    spd_lock_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .lp_init(lp_init),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
        .sat_hit(sat_hit), .cnt_live(cnt), .range_flag(range_flag),
        .reg_rdata(reg_rdata), .upper(upper), .lower(lower),
        .ctrl(ctrl), .ovf(ovf), .ctrl_wr(ctrl_wr)
    );

    spd_lock_window #(.DATA_W(DATA_W), .HAS_LIMIT(HAS_LIMIT)) u_win (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .upper(upper), .lower(lower), .lim_en(lim_en_w),
        .in_range(in_range), .sat_hit(sat_hit),
        .out_valid(out_valid), .out_data(out_data)
    );

    spd_lock_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .lp_init(lp_init),
        .smp_valid(smp_valid), .in_range(in_range), .lock_en(lock_en_w),
        .ctrl_wr(ctrl_wr), .preset(ctrl.preset), .ld_val(reg_wdata[CNT_W-1:0]),
        .cnt(cnt), .lock_o(lock_o), .range_flag(range_flag)
    );
endmodule

// File: rtl/spd_lock_checker.sv
// Assertion checker for spd_lock_limiter, attached by bind below.
module spd_lock_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_valid,
    input logic [DATA_W-1:0] smp_data,
    input logic              in_range,
    input logic              sat_hit,
    input logic              lock_en,
    input logic              lim_en,
    input logic [DATA_W-1:0] upper,
    input logic [DATA_W-1:0] lower,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              lock_o,
    input logic              range_flag,
    input logic              ovf,
    input logic [1:0]        reg_addr,
    input logic [DATA_W-1:0] reg_rdata
);
    // R9
    out_valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> out_valid);
    // R9
    out_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !out_valid);
    // R9
    clamp_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(lim_en) && ($signed($past(lower)) <= $signed($past(upper))))
        |-> (($signed(out_data) >= $signed($past(lower))) && ($signed(out_data) <= $signed($past(upper)))));
    // R9
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(lim_en)) |-> (out_data == $past(smp_data)));
    // R5
    lock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(smp_valid && in_range && lock_en));
    // R6
    miss_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !in_range) |=> (!lock_o && range_flag));
    // R8
    disabled_no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_en |=> !lock_o);
    // R10
    sat_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sat_hit |=> ovf);
    // R2
    bound_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != 2'd2) |-> (reg_rdata == '0));
endmodule

bind spd_lock_limiter spd_lock_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .in_range(in_range), .sat_hit(sat_hit), .lock_en(lock_en_w), .lim_en(lim_en_w),
    .upper(upper), .lower(lower), .out_valid(out_valid), .out_data(out_data),
    .lock_o(lock_o), .range_flag(range_flag), .ovf(ovf),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/spd_lock_limiter_test.sv
module spd_lock_limiter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lp_init = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [1:0]  reg_be = 2'b00;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = 16'h0;
    logic        out_valid;
    logic [15:0] out_data;
    logic        lock_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference model state
    logic signed [15:0] m_hi, m_lo;
    logic [1:0] m_mode, m_preset, m_cnt;
    logic m_ovf, m_lim, m_rflag, m_en, m_lock;
    logic [15:0] m_out;

    always #4 clk = ~clk;

    spd_lock_limiter uut (
        .clk(clk), .rst_n(rst_n), .lp_init(lp_init),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .smp_valid(smp_valid), .smp_data(smp_data),
        .out_valid(out_valid), .out_data(out_data), .lock_o(lock_o)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_hi = 16'sh7FFF; m_lo = 16'sh8000;
        m_mode = 0; m_preset = 0; m_cnt = 0;
        m_ovf = 0; m_lim = 0; m_rflag = 0; m_en = 0; m_lock = 0;
    endtask

    task automatic wr(logic [1:0] a, logic [1:0] be, logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = 2'b00;
        if (a == 2'd0 && be == 2'b11) m_hi = d;
        if (a == 2'd1 && be == 2'b11) m_lo = d;
        if (a == 2'd2 && be[0]) begin
            m_mode = d[7:6]; if (!d[5]) m_ovf = 1'b0;
            m_lim = d[4]; m_en = d[2]; m_preset = d[1:0];
            m_cnt = d[1:0]; m_lock = 1'b0;
        end
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic chk_ctrl(string req);
        logic [15:0] d;
        rd(2'd2, d);
        chk(req, d, {8'h00, m_mode, m_ovf, m_lim, m_rflag, m_en, m_cnt});
    endtask

    task automatic send(logic [15:0] s);
        logic signed [15:0] v;
        logic inr;
        v = s;
        @(negedge clk);
        smp_valid = 1'b1; smp_data = s;
        @(negedge clk);
        smp_valid = 1'b0;
        inr = (v >= m_lo) && (v <= m_hi);
        if (s == 16'h7FFF || s == 16'h8000) m_ovf = 1'b1;
        m_rflag = !inr;
        if (!m_en) begin m_cnt = m_preset; m_lock = 1'b0; end
        else if (inr) begin
            if (m_cnt == 0) m_lock = 1'b1; else m_cnt = m_cnt - 1'b1;
        end else begin m_cnt = m_preset; m_lock = 1'b0; end
        m_out = s;
        if (m_lim && v < m_lo) m_out = m_lo;
        else if (m_lim && v > m_hi) m_out = m_hi;
        chk("R9 valid", {15'h0, out_valid}, 16'h1);
        chk("R9 data", out_data, m_out);
        chk("R5 lock", {15'h0, lock_o}, {15'h0, m_lock});
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk("R1 lock", {15'h0, lock_o}, 16'h0);
        chk_ctrl("R1 ctrl");
        rd(2'd0, d); chk("R2 upper read", d, 16'h0);
        rd(2'd1, d); chk("R2 lower read", d, 16'h0);
        rd(2'd3, d); chk("R2 addr3 read", d, 16'h0);
        send(16'h1234);
        wr(2'd2, 2'b01, 16'h0010);
        send(16'h7FFE);
        send(16'h8001);
        chk_ctrl("R1 extremes in window");
    endtask

    task automatic t_bounds();
        wr(2'd0, 2'b11, 16'h0100);
        wr(2'd1, 2'b11, 16'hFF00);
        wr(2'd0, 2'b01, 16'h0050);
        wr(2'd1, 2'b10, 16'h0000);
        send(16'h0200);
        chk("R3 upper kept", out_data, 16'h0100);
        send(16'hFED4);
        chk("R3 lower kept", out_data, 16'hFF00);
        send(16'h0100);
        chk_ctrl("R4 upper edge inclusive");
        send(16'h0101);
        chk_ctrl("R4 just above");
        send(16'hFF00);
        chk_ctrl("R4 lower edge inclusive");
        send(16'hFEFF);
        chk_ctrl("R4 just below");
    endtask

    task automatic t_lock(logic [1:0] p);
        wr(2'd2, 2'b01, {8'h00, 6'b000101, p});
        for (int i = 0; i <= p; i++) begin
            send(16'h0010);
            chk("R5 lock timing", {15'h0, lock_o}, {15'h0, (i == p)});
            chk_ctrl("R7 live count");
        end
        send(16'hFF00);
        chk("R5 lock holds", {15'h0, lock_o}, 16'h1);
        send(16'h0300);
        chk("R6 miss clears lock", {15'h0, lock_o}, 16'h0);
        chk_ctrl("R6 reload and flag");
        send(16'h0000);
        chk_ctrl("R6 flag clears");
    endtask

    task automatic t_disabled();
        wr(2'd2, 2'b01, 16'h0011);
        for (int i = 0; i < 4; i++) send(16'h0020);
        chk("R8 no lock", {15'h0, lock_o}, 16'h0);
        chk_ctrl("R8 counter held");
    endtask

    task automatic t_ctrl_fields();
        send(16'h7FFF);
        chk_ctrl("R10 set on max");
        wr(2'd2, 2'b01, 16'h0030);
        chk_ctrl("R10 write 1 keeps");
        wr(2'd2, 2'b01, 16'h0010);
        chk_ctrl("R10 write 0 clears");
        send(16'h8000);
        chk_ctrl("R10 set on min");
        send(16'h0500);
        wr(2'd2, 2'b01, 16'h00C0);
        chk_ctrl("R11 mode and ro bit");
        wr(2'd2, 2'b01, 16'h0048);
        chk_ctrl("R11 bit3 ignored");
    endtask

    task automatic t_midwrite();
        wr(2'd2, 2'b01, 16'h0017);
        send(16'h0001);
        send(16'h0002);
        chk_ctrl("R12 counting");
        wr(2'd2, 2'b01, 16'h0014);
        chk_ctrl("R12 reload");
        send(16'h0003);
        chk("R12 lock after reload", {15'h0, lock_o}, 16'h1);
        wr(2'd2, 2'b01, 16'h0015);
        chk("R12 write clears lock", {15'h0, lock_o}, 16'h0);
    endtask

    task automatic t_lowpower();
        wr(2'd2, 2'b01, 16'h0014);
        send(16'h0000);
        @(negedge clk); lp_init = 1'b1;
        @(negedge clk); lp_init = 1'b0;
        model_reset();
        chk("R13 lock", {15'h0, lock_o}, 16'h0);
        chk_ctrl("R13 ctrl");
        wr(2'd2, 2'b01, 16'h0010);
        send(16'h0200);
        chk("R13 bounds restored", out_data, 16'h0200);
    endtask

    task automatic t_random();
        logic [15:0] s;
        wr(2'd0, 2'b11, 16'h0040);
        wr(2'd1, 2'b11, 16'hFFC0);
        wr(2'd2, 2'b01, 16'h0015);
        for (int i = 0; i < 150; i++) begin
            s = 16'($urandom_range(0, 191)) - 16'd64;
            if (i % 37 == 5) s = 16'h7FFF;
            if (i % 41 == 9) s = 16'h8000;
            send(s);
        end
        chk_ctrl("R6 random final ctrl");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bounds();
        for (int p = 0; p < 4; p++) t_lock(2'(p));
        t_disabled();
        t_ctrl_fields();
        t_midwrite();
        t_lowpower();
        t_random();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule